// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port and applies their set and clear rules. The shift-register logic reports events to it as one-cycle pulses: a byte moved from the transmit holding register into the transmitter, the last bit of a character leaving the line, and a received character completing, together with its framing result, parity result and multiprocessor bit. A DMA-style transfer controller can also clear the data flags when it services the port. The CPU reads and writes the register over a simple byte bus.

Software can only clear a flag that it has already seen set. A read of the register remembers which flags read as 1. A later write of 0 to such a bit clears it. Writing 1 to a flag bit never sets it. The block also drives a strobe that tells the receive data register whether to take a new character. On overrun the strobe stays low, so the old byte survives and the new one is lost.

Top module: `sci_status_flags`

## Requirements
- R1: After reset the status register reads 0x84, with only the transmit-empty bit (bit 7) and the transmit-end bit (bit 2) set. The three interrupt outputs and `rx_accept` are 0.
- R2: Status bits from MSB to LSB are: transmit empty (7), receive full (6), overrun (5), framing error (4), parity error (3), transmit end (2), received multiprocessor bit (1), multiprocessor bit to send (0). `bus_rdata` shows them while `bus_rd` is high and `bus_addr` equals `STAT_ADDR`, and is 0 at any other time.
- R3: A status write clears bit 7, 6, 5, 4 or 3 only when the data bit is 0 and the most recent status read since the previous status write saw that flag at 1. Writing 1 to these bits has no effect. Every status write consumes all the remembered reads.
- R4: If hardware sets a flag between the read and the clearing write, the remembered read for that flag is cancelled and the write does not clear it.
- R5: When a hardware set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: `tx_load` sets transmit empty. `xfer_tx_write` clears transmit empty and transmit end. A software clear of transmit empty also clears transmit end.
- R7: While `tx_en` is 0, transmit empty and transmit end are held at 1.
- R8: `tx_last_bit` sets transmit end only if transmit empty is 1 in that cycle.
- R9: A completed character with no framing or parity error, received while receive full is 0, sets receive full and stores `rx_mpb` in bit 1. It also raises `rx_accept` in the same cycle. `xfer_rx_read` clears receive full.
- R10: A character that completes while receive full is 1 sets overrun. In that case `rx_accept` stays low and receive full and bit 1 are unchanged.
- R11: `rx_frame_err` sets the framing flag and `rx_parity_err` sets the parity flag. A character with either error raises no `rx_accept` and leaves receive full unchanged.
- R12: While `rx_en` is 0, receive completion events have no effect.
- R13: Bit 0 follows the written data bit on every status write. Bit 1 is read-only.
- R14: `irq_tx` = transmit empty AND `tx_irq_en`. `irq_rx` = receive full AND `rx_irq_en`. `irq_err` = overrun OR framing OR parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | CPU register address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| xfer_tx_write | input | 1 | Transfer controller wrote the transmit holding register |
| xfer_rx_read | input | 1 | Transfer controller read the receive data register |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_load | input | 1 | Holding byte moved into the transmit shifter |
| tx_last_bit | input | 1 | Last bit of a character transmitted |
| rx_done | input | 1 | Received character complete |
| rx_frame_err | input | 1 | Stop bit sampled as 0 (valid with rx_done) |
| rx_parity_err | input | 1 | Parity mismatch (valid with rx_done) |
| rx_mpb | input | 1 | Received multiprocessor bit (valid with rx_done) |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_accept | output | 1 | Load the received character into the receive data register |
| mpb_tx | output | 1 | Multiprocessor bit to transmit |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The assertions check every cycle that disabling the transmitter forces both transmit flags high and that a transmit-empty set wins over a clear in the same cycle. They also check that an overrun keeps receive full and the stored multiprocessor bit, that a disabled receiver freezes them, and that two back-to-back writes never both clear. The read-then-write clear protocol is shown only by the bench's scenarios. These include a write with no prior read, a write after the remembered reads were consumed, and a read whose remembered value is cancelled by a fresh hardware set. Exact register values after each event sequence, and the same-cycle `rx_accept` strobe, are also left to the bench.

// File: rtl/sci_stat_pkg.sv
package sci_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int GUARD_N  = 5;   // flags in bits 7..3 use the guarded clear
    localparam int GUARD_LO = 3;

    // Packed order equals register layout, MSB first.
    typedef struct packed {
        logic txe;     // 7 transmit holding register empty
        logic rxf;     // 6 receive data register full
        logic ovr;     // 5 overrun
        logic frm;     // 4 framing error
        logic par;     // 3 parity error
        logic tend;    // 2 transmit end
        logic mpb_rx;  // 1 received multiprocessor bit
        logic mpb_tx;  // 0 multiprocessor bit to send
    } stat_t;

    typedef struct packed {
        logic done;
        logic frm;
        logic par;
        logic mpb;
    } rx_ev_t;

    localparam stat_t STAT_RESET = '{txe: 1'b1, tend: 1'b1, default: 1'b0};

    function automatic logic [GUARD_N-1:0] guard_bits(input stat_t s);
        return {s.txe, s.rxf, s.ovr, s.frm, s.par};
    endfunction

endpackage

// File: rtl/sci_clr_guard.sv
module sci_clr_guard #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] wzero,
    output logic [N-1:0] clr
);
    logic [N-1:0] arm;

    for (genvar i = 0; i < N; i++) begin : g_arm
        always_ff @(posedge clk) begin
            if (rst)            arm[i] <= 1'b0;
            else if (wr_hit)    arm[i] <= 1'b0;
            else if (hw_set[i]) arm[i] <= 1'b0;
            else if (rd_hit)    arm[i] <= cur[i];
        end
    end

    assign clr = {N{wr_hit}} & wzero & arm;

    // R3: a write consumes the remembered reads, so a second write clears nothing
    assert_single_clear_R3: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (clr == '0));

endmodule

// File: rtl/sci_tx_flags.sv
module sci_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic load,
    input  logic xfer_wr,
    input  logic last_bit,
    input  logic sw_clr_txe,
    output logic txe,
    output logic tend
);
    logic clr_any;
    assign clr_any = xfer_wr | sw_clr_txe;

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            txe  <= 1'b1;
            tend <= 1'b1;
        end else begin
            txe  <= load | (txe & ~clr_any);
            tend <= (last_bit & txe) | (tend & ~clr_any);
        end
    end

    assert_tx_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (txe && tend));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (load && clr_any) |=> txe);

    assert_tend_needs_txe_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(tend) && $past(tx_en)) |-> $past(txe && last_bit));

endmodule

// File: rtl/sci_rx_flags.sv
module sci_rx_flags
    import sci_stat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rx_en,
    input  rx_ev_t ev,
    input  logic   xfer_rd,
    input  logic   sw_clr_rxf,
    input  logic   sw_clr_ovr,
    input  logic   sw_clr_frm,
    input  logic   sw_clr_par,
    output logic   rxf,
    output logic   ovr,
    output logic   frm,
    output logic   par,
    output logic   mpb,
    output logic   accept,
    output logic   set_ovr,
    output logic   set_frm,
    output logic   set_par
);
    logic done_v, err;

    assign done_v  = rx_en & ev.done;
    assign err     = ev.frm | ev.par;
    assign accept  = done_v & ~err & ~rxf;
    assign set_ovr = done_v & rxf;
    assign set_frm = done_v & ev.frm;
    assign set_par = done_v & ev.par;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxf <= 1'b0;
            ovr <= 1'b0;
            frm <= 1'b0;
            par <= 1'b0;
            mpb <= 1'b0;
        end else begin
            rxf <= accept  | (rxf & ~(xfer_rd | sw_clr_rxf));
            ovr <= set_ovr | (ovr & ~sw_clr_ovr);
            frm <= set_frm | (frm & ~sw_clr_frm);
            par <= set_par | (par & ~sw_clr_par);
            if (accept) mpb <= ev.mpb;
        end
    end

    assert_overrun_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_en && ev.done && rxf && !xfer_rd && !sw_clr_rxf)
        |=> (ovr && rxf && $stable(mpb)));

    assert_rx_off_R12: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !xfer_rd && !sw_clr_rxf) |=> ($stable(rxf) && $stable(mpb)));

    assert_err_no_load_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_en && ev.done && (ev.frm || ev.par) && !xfer_rd && !sw_clr_rxf)
        |=> ((frm || par) && $stable(rxf) && $stable(mpb)));

endmodule

// File: rtl/sci_status_flags.sv
module sci_status_flags
    import sci_stat_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              xfer_tx_write,
    input  logic              xfer_rx_read,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_load,
    input  logic              tx_last_bit,
    input  logic              rx_done,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              rx_mpb,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    output logic              rx_accept,
    output logic              mpb_tx,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    localparam int GHI = GUARD_LO + GUARD_N - 1;

    stat_t              stat;
    rx_ev_t             rx_ev;
    logic               rd_hit, wr_hit;
    logic [GUARD_N-1:0] hw_set, sw_clr;
    logic               set_ovr, set_frm, set_par;
    logic               mpbt_q;

    assign rd_hit = bus_rd & (bus_addr == STAT_ADDR);
    assign wr_hit = bus_wr & (bus_addr == STAT_ADDR);

    assign rx_ev = '{done: rx_done, frm: rx_frame_err, par: rx_parity_err, mpb: rx_mpb};

    // hw_set/sw_clr index 4..0 = transmit empty, receive full, overrun, framing, parity
    assign hw_set = {~tx_en | tx_load, rx_accept, set_ovr, set_frm, set_par};

    sci_clr_guard #(.N(GUARD_N)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit),
        .cur    (guard_bits(stat)),
        .hw_set (hw_set),
        .wzero  (~bus_wdata[GHI:GUARD_LO]),
        .clr    (sw_clr)
    );

    sci_tx_flags u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .load       (tx_load),
        .xfer_wr    (xfer_tx_write),
        .last_bit   (tx_last_bit),
        .sw_clr_txe (sw_clr[4]),
        .txe        (stat.txe),
        .tend       (stat.tend)
    );

    sci_rx_flags u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .ev         (rx_ev),
        .xfer_rd    (xfer_rx_read),
        .sw_clr_rxf (sw_clr[3]),
        .sw_clr_ovr (sw_clr[2]),
        .sw_clr_frm (sw_clr[1]),
        .sw_clr_par (sw_clr[0]),
        .rxf        (stat.rxf),
        .ovr        (stat.ovr),
        .frm        (stat.frm),
        .par        (stat.par),
        .mpb        (stat.mpb_rx),
        .accept     (rx_accept),
        .set_ovr    (set_ovr),
        .set_frm    (set_frm),
        .set_par    (set_par)
    );

    always_ff @(posedge clk) begin
        if (rst)         mpbt_q <= STAT_RESET.mpb_tx;
        else if (wr_hit) mpbt_q <= bus_wdata[0];
    end
    assign stat.mpb_tx = mpbt_q;
    assign mpb_tx      = mpbt_q;

    assign bus_rdata = rd_hit ? 8'(stat) : 8'h00;
    assign irq_tx    = stat.txe & tx_irq_en;
    assign irq_rx    = stat.rxf & rx_irq_en;
    assign irq_err   = stat.ovr | stat.frm | stat.par;

    assert_ovr_only_on_rx_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.ovr) |-> $past(rx_en && rx_done));

    assert_mpb_readonly_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !(rx_en && rx_done)) |=> $stable(stat.mpb_rx));

endmodule

// File: tb/tb_sci_status_flags.sv
module tb_sci_status_flags;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] SA = 4;

    localparam logic [3:0] OP_NOP = 0, OP_TXLD = 1, OP_TXWR = 2, OP_LAST = 3,
                           OP_RXOK = 4, OP_RXFE = 5, OP_RXPE = 6, OP_SWWR = 7;

    // {op, data, expected status after op}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {OP_TXWR, 8'h00, 8'h00},  // R6
        {OP_LAST, 8'h00, 8'h00},  // R8 no set while empty=0
        {OP_TXLD, 8'h00, 8'h80},  // R6
        {OP_LAST, 8'h00, 8'h84},  // R8
        {OP_RXOK, 8'h01, 8'hC6},  // R9
        {OP_RXOK, 8'h00, 8'hE6},  // R10
        {OP_SWWR, 8'hBF, 8'hA7},  // R3 R13
        {OP_SWWR, 8'hDE, 8'h86},  // R3 R13
        {OP_RXFE, 8'h00, 8'h96},  // R11
        {OP_RXPE, 8'h00, 8'h9E},  // R11
        {OP_SWWR, 8'h00, 8'h02},  // R3 R6
        {OP_RXOK, 8'h00, 8'h40},  // R9
        {OP_NOP,  8'h00, 8'h40},
        {OP_SWWR, 8'hFF, 8'h41}   // R3 R13
    };

    logic clk = 0, rst = 1;
    logic [ADDR_W-1:0] bus_addr = SA;
    logic bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic xfer_tx_write = 0, xfer_rx_read = 0, tx_en = 1, rx_en = 1;
    logic tx_load = 0, tx_last_bit = 0, rx_done = 0, rx_frame_err = 0;
    logic rx_parity_err = 0, rx_mpb = 0, tx_irq_en = 0, rx_irq_en = 0;
    logic rx_accept, mpb_tx, irq_tx, irq_rx, irq_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sci_status_flags #(.ADDR_W(ADDR_W), .STAT_ADDR(SA)) dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_stat(output logic [7:0] v);
        bus_addr = SA; bus_rd = 1; #1;
        v = bus_rdata;
        step();
        bus_rd = 0;
    endtask

    task automatic set_op(input logic [3:0] op, input logic [7:0] d);
        case (op)
            OP_TXLD: tx_load = 1;
            OP_TXWR: xfer_tx_write = 1;
            OP_LAST: tx_last_bit = 1;
            OP_RXOK: begin rx_done = 1; rx_mpb = d[0]; end
            OP_RXFE: begin rx_done = 1; rx_frame_err = 1; end
            OP_RXPE: begin rx_done = 1; rx_parity_err = 1; end
            OP_SWWR: begin bus_addr = SA; bus_wr = 1; bus_wdata = d; end
            default: ;
        endcase
    endtask

    task automatic clr_op();
        tx_load = 0; xfer_tx_write = 0; tx_last_bit = 0; rx_done = 0; rx_mpb = 0;
        rx_frame_err = 0; rx_parity_err = 0; bus_wr = 0; xfer_rx_read = 0;
    endtask

    task automatic do_op(input logic [3:0] op, input logic [7:0] d);
        set_op(op, d);
        step();
        clr_op();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        @(negedge clk); step(); rst = 0;
        // R1
        rd_stat(v); chk("R1 reset value", v, 8'h84);
        chk("R1 irqs", {5'b0, irq_tx, irq_rx, irq_err}, 8'h00);
        chk("R1 rx_accept", {7'b0, rx_accept}, 8'h00);
        // R2
        #1 chk("R2 idle rdata", bus_rdata, 8'h00);
        bus_addr = SA + 1; bus_rd = 1; #1;
        chk("R2 other address", bus_rdata, 8'h00);
        bus_rd = 0; bus_addr = SA;

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][19:16], VEC[i][15:8]);
            rd_stat(v);
            chk($sformatf("R2/R3/R6/R8-R11/R13 vector %0d", i), v, VEC[i][7:0]);
        end

        // R5: set and clear of transmit empty in the same cycle
        do_op(OP_TXLD, 0);
        rd_stat(v); chk("R6 load sets empty", v, 8'hC1);
        set_op(OP_SWWR, 8'h7F); tx_load = 1; step(); clr_op();
        rd_stat(v); chk("R5 set wins", v, 8'hC1);
        // R3: write without remembered read, and after consumed read
        do_op(OP_SWWR, 8'hFF);
        do_op(OP_SWWR, 8'hBF);
        rd_stat(v); chk("R3 no read no clear", v, 8'hC1);
        do_op(OP_SWWR, 8'hBF);
        rd_stat(v); chk("R3 read then clear", v, 8'h81);
        // R4
        do_op(OP_RXFE, 0);
        rd_stat(v); chk("R11 framing set", v, 8'h91);
        do_op(OP_RXFE, 0);
        do_op(OP_SWWR, 8'hEF);
        rd_stat(v); chk("R4 cancelled arm", v, 8'h91);
        do_op(OP_SWWR, 8'hEF);
        rd_stat(v); chk("R4 normal clear", v, 8'h81);
        // R9
        set_op(OP_RXOK, 8'h01); #1;
        chk("R9 accept strobe", {7'b0, rx_accept}, 8'h01);
        step(); clr_op();
        xfer_rx_read = 1; step(); clr_op();
        rd_stat(v); chk("R9 transfer read clears", v, 8'h83);
        do_op(OP_RXOK, 8'h01);
        // R10
        set_op(OP_RXOK, 8'h00); #1;
        chk("R10 no accept on overrun", {7'b0, rx_accept}, 8'h00);
        step(); clr_op();
        rd_stat(v); chk("R10 overrun keeps data", v, 8'hE3);
        // R14
        tx_irq_en = 1; rx_irq_en = 1; #1;
        chk("R14 irqs set", {5'b0, irq_tx, irq_rx, irq_err}, 8'h07);
        do_op(OP_SWWR, 8'h9F);
        #1 chk("R14 irqs after clear", {5'b0, irq_tx, irq_rx, irq_err}, 8'h04);
        tx_irq_en = 0; #1;
        chk("R14 tx gate", {5'b0, irq_tx, irq_rx, irq_err}, 8'h00);
        // R12
        rx_en = 0;
        set_op(OP_RXOK, 8'h00); #1;
        chk("R12 no accept disabled", {7'b0, rx_accept}, 8'h00);
        step(); clr_op();
        rd_stat(v); chk("R12 receiver off", v, 8'h83);
        rx_en = 1;
        // R7
        do_op(OP_TXWR, 0);
        rd_stat(v); chk("R6 transfer write clears", v, 8'h03);
        tx_en = 0; step();
        rd_stat(v); chk("R7 disabled forces", v, 8'h87);
        do_op(OP_TXWR, 0);
        rd_stat(v); chk("R7 held while disabled", v, 8'h87);
        finish_run();
    end

endmodule